// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block moves bytes between an 8-bit processor bus and a three-wire serial link: a data output, a data input and a shift clock. Transmit and receive share one shift clock, so every byte sent also clocks one byte in. The shift clock is made inside the block from a reload-counter divider or comes from outside through a synchronizer. Each direction has one buffer in front of its shift register. Four flags report the state of the transfer. Two outputs give one-cycle interrupt pulses, one for transmit and one for receive.

In internal-clock mode, software picks the divider reload value and the prescale. It then writes a byte to the data address, and that write starts the transfer. If the next byte is written before the current one has finished shifting, the second byte follows the first with no pause in the clock. The transmit interrupt can signal either that the buffer can take another byte or that the serial line has gone quiet. In external-clock mode the peer drives the clock. The block then shifts only while a byte is waiting to be sent or is being sent.

Top module: `ssp_sync_port`

Register map (2-bit address): 0 = data (a write loads the transmit buffer, a read returns the receive buffer), 1 = status, 2 = control, 3 = divider reload.

## Requirements
- R1: After reset the status register reads 0x05, the control and reload registers read 0x00, the shift clock output is high and its output enable is low.
- R2: When control bit 6 (enable) and bit 0 (internal clock) are both 1, a write to address 0 starts a transfer. The output changes on each falling shift-clock edge, least significant bit first. The input is sampled on each rising edge. One byte takes 8 clocks.
- R3: In internal mode each half period of the shift clock lasts (n+1)·P core cycles. Here n is the value at address 3, and P is 4 when control bit 1 is 1, otherwise 1. This gives clock rates from 1/2 down to 1/2048 of the core clock.
- R4: Status bit 0 (TBE) clears when address 0 is written and sets when the byte moves into the shift register. Status bit 2 (TSC) clears when shifting starts and sets on the 8th rising edge if no further byte is waiting.
- R5: A byte written before the current byte completes is sent immediately after it. The spacing of the shift-clock falling edges stays the same across the byte boundary.
- R6: Status bit 1 (RBF) sets on the 8th rising edge. Address 0 then reads the received byte, and that read clears RBF. The output rx_irq pulses for one cycle in the same cycle that RBF rises.
- R7: If a byte completes while RBF is still 1, status bit 3 (OE) sets, the receive buffer takes the newer byte and rx_irq does not pulse. Any write to address 1 clears OE.
- R8: tx_irq is a one-cycle pulse. When control bit 3 is 0 it comes in the cycle TBE rises. When control bit 3 is 1 it comes in the cycle TSC rises.
- R9: With control bit 6 at 0 no transfer starts and the shift clock stays high. A byte written meanwhile stays in the buffer with TBE at 0 and is sent once bit 6 is set.
- R10: With control bit 0 at 0, the clock output enable is low and shifting follows the edges of sclk_in after a two-stage synchronizer. Each sclk_in phase must last at least 6 core cycles. Edges that arrive while no byte is waiting or shifting are ignored.
- R11: The control and reload registers read back the last value written to them. Status bits 7 to 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (clears RBF at address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sclk_out | output | 1 | Internally generated shift clock, idle high |
| sclk_out_en | output | 1 | High when sclk_out should drive the clock line |
| sclk_in | input | 1 | External shift clock |
| ser_out | output | 1 | Serial data output |
| ser_in | input | 1 | Serial data input |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench uses the default parameters: an 8-bit data path, an 8-bit reload, a prescale of 4 and a two-stage clock synchronizer. With these values, random reload values from 0 to 5 are mixed with both prescale settings, and a directed case uses the largest divisor, a reload of 255 with prescale. This covers both ends of the clock-rate range. A bench model of the peer records every shift-clock edge, so the bench can check the spacing of the edges, the bits on the output and the timing of both interrupts against the edge counts. The bench also runs the external clock path with slow clock phases.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_DIV  = 2'd3
  } ssp_addr_e;

  // control register bit positions
  localparam int CTL_INTCLK = 0;
  localparam int CTL_SLOW   = 1;
  localparam int CTL_TISEL  = 3;
  localparam int CTL_EN     = 6;

  // status register bit positions
  localparam int ST_TBE = 0;
  localparam int ST_RBF = 1;
  localparam int ST_TSC = 2;
  localparam int ST_OE  = 3;
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int DIV_W   = 8,
  parameter int PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             slow_i,
  input  logic [DIV_W-1:0] reload_i,
  output logic             tick_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic             pre_tick;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q, pre_d;
      localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_DIV - 1);

      assign pre_tick = !slow_i || (pre_q == PRE_MAX);

      always_comb begin
        pre_d = pre_q;
        if (!run_i || !slow_i)  pre_d = '0;
        else if (pre_q == PRE_MAX) pre_d = '0;
        else                    pre_d = pre_q + PRE_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_nopre
      assign pre_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)                cnt_d = reload_i;
    else if (pre_tick) begin
      if (cnt_q == '0)         cnt_d = reload_i;
      else                     cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && pre_tick && (cnt_q == '0);

  // after a tick the counter restarts from a non-zero reload, so no tick follows at once
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o && (reload_i != '0) |=> !tick_o)
    else $error("assert_tick_spacing_R3");
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              int_clk_i,
  input  logic              tick_i,
  input  logic              ext_fall_i,
  input  logic              ext_rise_i,
  input  logic              pending_i,
  input  logic [DATA_W-1:0] txbuf_i,
  input  logic              rxd_i,
  output logic              run_o,
  output logic              sclk_o,
  output logic              txd_o,
  output logic              load_o,
  output logic              done_o,
  output logic              stop_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              active_q, active_d;
  logic              need_load_q, need_load_d;
  logic              sclk_q, sclk_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] tx_sr_q, tx_sr_d;
  logic [DATA_W-1:0] rx_sr_q, rx_sr_d;

  logic mode_int, fall, rise, load, shift, sample, done;

  assign mode_int = en_i && int_clk_i;
  assign fall     = mode_int ? (tick_i && sclk_q)  : (en_i && ext_fall_i);
  assign rise     = mode_int ? (tick_i && !sclk_q) : (en_i && ext_rise_i);
  assign load     = fall && ((!active_q && pending_i) || need_load_q);
  assign shift    = fall && active_q && !need_load_q;
  assign sample   = rise && active_q && !need_load_q;
  assign done     = sample && (bitcnt_q == LAST_BIT);

  always_comb begin
    active_d    = active_q;
    need_load_d = need_load_q;
    bitcnt_d    = bitcnt_q;
    tx_sr_d     = tx_sr_q;
    rx_sr_d     = rx_sr_q;
    sclk_d      = sclk_q;

    if (!mode_int)   sclk_d = 1'b1;
    else if (tick_i) sclk_d = !sclk_q;

    if (load) begin
      active_d    = 1'b1;
      need_load_d = 1'b0;
      tx_sr_d     = txbuf_i;
    end else if (shift) begin
      tx_sr_d     = {1'b1, tx_sr_q[DATA_W-1:1]};
    end

    if (sample) begin
      rx_sr_d = {rxd_i, rx_sr_q[DATA_W-1:1]};
      if (done) begin
        bitcnt_d = '0;
        if (pending_i) need_load_d = 1'b1;
        else           active_d    = 1'b0;
      end else begin
        bitcnt_d = bitcnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      need_load_q <= 1'b0;
      sclk_q      <= 1'b1;
      bitcnt_q    <= '0;
      tx_sr_q     <= '1;
      rx_sr_q     <= '0;
    end else begin
      active_q    <= active_d;
      need_load_q <= need_load_d;
      sclk_q      <= sclk_d;
      bitcnt_q    <= bitcnt_d;
      tx_sr_q     <= tx_sr_d;
      rx_sr_q     <= rx_sr_d;
    end
  end

  assign run_o     = mode_int && (active_q || pending_i);
  assign sclk_o    = sclk_q;
  assign txd_o     = tx_sr_q[0];
  assign load_o    = load;
  assign done_o    = done;
  assign stop_o    = done && !pending_i;
  assign busy_o    = active_q;
  assign rx_byte_o = {rxd_i, rx_sr_q[DATA_W-1:1]};

  // an idle engine holds no partial byte
  assert_idle_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (bitcnt_q == '0) && !need_load_q)
    else $error("assert_idle_clean_R2");

  // a disabled port parks the clock high
  assert_park_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> sclk_q)
    else $error("assert_park_high_R9");
endmodule

// File: rtl/ssp_status.sv
module ssp_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              done_i,
  input  logic              stop_i,
  input  logic              busy_i,
  input  logic              rd_data_i,
  input  logic              clr_oe_i,
  input  logic              ti_sel_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic [DATA_W-1:0] tx_buf_o,
  output logic [DATA_W-1:0] rx_buf_o,
  output logic              tbe_o,
  output logic              rbf_o,
  output logic              tsc_o,
  output logic              oe_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  logic [DATA_W-1:0] tx_buf_q, tx_buf_d;
  logic [DATA_W-1:0] rx_buf_q, rx_buf_d;
  logic tbe_q, tbe_d, rbf_q, rbf_d, tsc_q, tsc_d, oe_q, oe_d;
  logic txi_q, txi_d, rxi_q, rxi_d;

  always_comb begin
    tx_buf_d = tx_buf_q;
    rx_buf_d = rx_buf_q;
    tbe_d    = tbe_q;
    rbf_d    = rbf_q;
    tsc_d    = tsc_q;
    oe_d     = oe_q;

    if (buf_wr_i) tx_buf_d = wdata_i;

    // a write in the load cycle is a new byte: buffer stays full
    if (buf_wr_i)    tbe_d = 1'b0;
    else if (load_i) tbe_d = 1'b1;

    if (load_i)      tsc_d = 1'b0;
    else if (stop_i) tsc_d = 1'b1;

    if (done_i) begin
      rx_buf_d = rx_byte_i;
      rbf_d    = 1'b1;
    end else if (rd_data_i) begin
      rbf_d    = 1'b0;
    end

    if (done_i && rbf_q && !rd_data_i) oe_d = 1'b1;
    else if (clr_oe_i)                 oe_d = 1'b0;

    txi_d = ti_sel_i ? (tsc_d && !tsc_q) : (tbe_d && !tbe_q);
    rxi_d = rbf_d && !rbf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf_q <= '0;
      rx_buf_q <= '0;
      tbe_q    <= 1'b1;
      rbf_q    <= 1'b0;
      tsc_q    <= 1'b1;
      oe_q     <= 1'b0;
      txi_q    <= 1'b0;
      rxi_q    <= 1'b0;
    end else begin
      tx_buf_q <= tx_buf_d;
      rx_buf_q <= rx_buf_d;
      tbe_q    <= tbe_d;
      rbf_q    <= rbf_d;
      tsc_q    <= tsc_d;
      oe_q     <= oe_d;
      txi_q    <= txi_d;
      rxi_q    <= rxi_d;
    end
  end

  assign tx_buf_o = tx_buf_q;
  assign rx_buf_o = rx_buf_q;
  assign tbe_o    = tbe_q;
  assign rbf_o    = rbf_q;
  assign tsc_o    = tsc_q;
  assign oe_o     = oe_q;
  assign tx_irq_o = txi_q;
  assign rx_irq_o = rxi_q;

  assert_rx_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxi_q |-> rbf_q)
    else $error("assert_rx_irq_flag_R6");

  assert_oe_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(rbf_q))
    else $error("assert_oe_needs_full_R7");

  // the engine's busy state and the shift-complete flag never agree
  assert_tsc_low_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !tsc_q)
    else $error("assert_tsc_low_busy_R4");

  assert_tx_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txi_q && ti_sel_i && $stable(ti_sel_i) |-> tsc_q && $past(!tsc_q))
    else $error("assert_tx_irq_pulse_R8");
endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        sclk_out,
  output logic        sclk_out_en,
  input  logic        sclk_in,
  output logic        ser_out,
  input  logic        ser_in,
  output logic        tx_irq,
  output logic        rx_irq
);
  import ssp_pkg::*;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // registers
  logic [7:0]       ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic wr_data, wr_stat, wr_ctrl, wr_div, rd_data;

  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_div  = bus_wr && (bus_addr == ADDR_DIV);
  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    if (wr_ctrl) ctrl_d = bus_wdata;
    if (wr_div)  div_d  = DIV_W'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
    end
  end

  logic en, int_clk, slow, ti_sel;
  assign en      = ctrl_q[CTL_EN];
  assign int_clk = ctrl_q[CTL_INTCLK];
  assign slow    = ctrl_q[CTL_SLOW];
  assign ti_sel  = ctrl_q[CTL_TISEL];

  // external clock synchronizer and edge detect
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   ext_prev_q, ext_prev_d;
  logic                   ext_now, ext_fall, ext_rise;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], sclk_in};
    end else begin : g_sync_one
      assign sync_d = sclk_in;
    end
  endgenerate

  assign ext_now    = sync_q[SYNC_STAGES-1];
  assign ext_prev_d = ext_now;
  assign ext_fall   = ext_prev_q && !ext_now;
  assign ext_rise   = !ext_prev_q && ext_now;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sync_q     <= '1;
      ext_prev_q <= 1'b1;
    end else begin
      sync_q     <= sync_d;
      ext_prev_q <= ext_prev_d;
    end
  end

  // sub-blocks
  logic              run, tick, load, done, stop, busy;
  logic              tbe, rbf, tsc, oe;
  logic [DATA_W-1:0] tx_buf, rx_buf, rx_byte;

  ssp_baud #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_baud (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run_i    (run),
    .slow_i   (slow),
    .reload_i (div_q),
    .tick_o   (tick)
  );

  ssp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sn),
    .en_i       (en),
    .int_clk_i  (int_clk),
    .tick_i     (tick),
    .ext_fall_i (ext_fall),
    .ext_rise_i (ext_rise),
    .pending_i  (!tbe),
    .txbuf_i    (tx_buf),
    .rxd_i      (ser_in),
    .run_o      (run),
    .sclk_o     (sclk_out),
    .txd_o      (ser_out),
    .load_o     (load),
    .done_o     (done),
    .stop_o     (stop),
    .busy_o     (busy),
    .rx_byte_o  (rx_byte)
  );

  ssp_status #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_sn),
    .buf_wr_i  (wr_data),
    .wdata_i   (DATA_W'(bus_wdata)),
    .load_i    (load),
    .done_i    (done),
    .stop_i    (stop),
    .busy_i    (busy),
    .rd_data_i (rd_data),
    .clr_oe_i  (wr_stat),
    .ti_sel_i  (ti_sel),
    .rx_byte_i (rx_byte),
    .tx_buf_o  (tx_buf),
    .rx_buf_o  (rx_buf),
    .tbe_o     (tbe),
    .rbf_o     (rbf),
    .tsc_o     (tsc),
    .oe_o      (oe),
    .tx_irq_o  (tx_irq),
    .rx_irq_o  (rx_irq)
  );

  assign sclk_out_en = en && int_clk;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_DATA: bus_rdata = 8'(rx_buf);
      ADDR_STAT: begin
        bus_rdata[ST_TBE] = tbe;
        bus_rdata[ST_RBF] = rbf;
        bus_rdata[ST_TSC] = tsc;
        bus_rdata[ST_OE]  = oe;
      end
      ADDR_CTRL: bus_rdata = ctrl_q;
      default:   bus_rdata = 8'(div_q);
    endcase
  end

  // while the clock output is not enabled, the internal clock stays parked high
  assert_ext_parked_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !sclk_out_en |=> sclk_out)
    else $error("assert_ext_parked_R10");
endmodule

// File: tb/test_ssp_sync_port.sv
module test_ssp_sync_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk_out, sclk_out_en, ser_out, tx_irq, rx_irq;
  logic       sclk_drv = 1'b1;
  logic       ext_mode = 1'b0, ext_rxd = 1'b1, mon_rxd = 1'b1;
  logic       ser_in;

  assign ser_in = ext_mode ? ext_rxd : mon_rxd;

  always #2 clk = ~clk;

  ssp_sync_port i_ssp_sync_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_out(sclk_out),
    .sclk_out_en(sclk_out_en), .sclk_in(sclk_drv), .ser_out(ser_out), .ser_in(ser_in),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int vectors = 0, fails = 0;
  int unsigned cyc = 0;
  localparam int WATCHDOG = 150000;

  // peer model: logs every shift-clock edge and interrupt
  int unsigned fall_cyc [0:1023];
  logic        fall_txd [0:1023];
  int unsigned rise_cyc [0:1023];
  logic        peer_bits[0:1023];
  int unsigned txi_cyc  [0:255];
  int unsigned rxi_cyc  [0:255];
  int nf = 0, nr = 0, ntx = 0, nrx = 0;
  logic prev_sclk = 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog expired actual %0d expected below %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (prev_sclk && !sclk_out) begin
      fall_cyc[nf] = cyc;
      fall_txd[nf] = ser_out;
      mon_rxd      = peer_bits[nf];
      nf = nf + 1;
    end
    if (!prev_sclk && sclk_out) begin
      rise_cyc[nr] = cyc;
      nr = nr + 1;
    end
    prev_sclk = sclk_out;
    if (tx_irq) begin txi_cyc[ntx] = cyc; ntx = ntx + 1; end
    if (rx_irq) begin rxi_cyc[nrx] = cyc; nrx = nrx + 1; end
  end

  task automatic chk(input string what, input int act, input int exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int half_period(input int n, input bit slow);
    return (n + 1) * (slow ? 4 : 1);
  endfunction

  function automatic logic [7:0] sent_byte(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = fall_txd[base + i];
    return b;
  endfunction

  function automatic int gap_errors(input int base, input int count, input int per);
    int e = 0;
    for (int i = 0; i < count - 1; i++)
      if (fall_cyc[base + i + 1] - fall_cyc[base + i] != per) e++;
    return e;
  endfunction

  task automatic set_peer(input int base, input logic [7:0] b);
    for (int i = 0; i < 8; i++) peer_bits[base + i] = b[i];
  endtask

  // one internal-clock byte with full checking
  task automatic int_byte(input int n, input bit slow, input bit tisel,
                          input logic [7:0] d, input logic [7:0] p, input bit mid_check);
    int bf, br, btx, brx;
    logic [7:0] r;
    bus_write(2'd2, 8'h41 | (8'(slow) << 1) | (8'(tisel) << 3));
    bus_write(2'd3, 8'(n));
    bf = nf; br = nr; btx = ntx; brx = nrx;
    set_peer(bf, p);
    bus_write(2'd0, d);
    if (mid_check) begin
      while (nr < br + 4) @(negedge clk);
      bus_read(2'd1, r);
      chk("R4 status mid-transfer TBE=1 TSC=0", r, 8'h01);
    end
    while (nr < br + 8) @(negedge clk);
    idle(3);
    chk("R2 bits sent LSB first", sent_byte(bf), d);
    chk("R3 falling-edge spacing errors", gap_errors(bf, 8, 2 * half_period(n, slow)), 0);
    chk("R3 rise after fall", rise_cyc[br] - fall_cyc[bf], half_period(n, slow));
    chk("R8 one tx_irq pulse", ntx - btx, 1);
    if (tisel) chk("R8 tx_irq on TSC rise", txi_cyc[btx], rise_cyc[br + 7]);
    else       chk("R8 tx_irq on TBE rise", txi_cyc[btx], fall_cyc[bf]);
    chk("R6 one rx_irq pulse", nrx - brx, 1);
    chk("R6 rx_irq with RBF rise", rxi_cyc[brx], rise_cyc[br + 7]);
    bus_read(2'd1, r);
    chk("R4 status after byte", r, 8'h07);
    bus_read(2'd0, r);
    chk("R6 received byte", r, p);
    bus_read(2'd1, r);
    chk("R6 read clears RBF", r, 8'h05);
  endtask

  task automatic ext_clock_byte(input logic [7:0] p, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sclk_drv = 1'b0; ext_rxd = p[i];
      idle(8);
      got[i] = ser_out;
      sclk_drv = 1'b1;
      idle(8);
    end
  endtask

  initial begin
    logic [7:0] r, a, b, pa, pb, g;
    int bf, br, btx, brx, seed;
    seed = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 1024; i++) peer_bits[i] = 1'b1;

    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_read(2'd1, r); chk("R1 status reset", r, 8'h05);
    bus_read(2'd2, r); chk("R1 control reset", r, 8'h00);
    bus_read(2'd3, r); chk("R1 reload reset", r, 8'h00);
    chk("R1 sclk_out idle high", sclk_out, 1);
    chk("R1 sclk_out_en low", sclk_out_en, 0);

    // R11 readback
    a = 8'($urandom) & 8'hB5;
    bus_write(2'd2, a); bus_read(2'd2, r); chk("R11 control readback", r, a);
    b = 8'($urandom);
    bus_write(2'd3, b); bus_read(2'd3, r); chk("R11 reload readback", r, b);
    bus_write(2'd2, 8'h00);

    // R2 R3 R4 R6 R8: fastest corner, then random mixes
    int_byte(0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1);
    for (int k = 0; k < 6; k++)
      int_byte(int'($urandom % 6), 1'($urandom), 1'($urandom),
               8'($urandom), 8'($urandom), 1'b1);

    // R3 slowest corner: reload 255 with prescale
    int_byte(255, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b0);

    // R5 back-to-back and R7 overrun
    pa = 8'($urandom); pb = 8'($urandom); a = 8'h5A; b = 8'hC3;
    bus_write(2'd2, 8'h41);
    bus_write(2'd3, 8'd1);
    bf = nf; br = nr; btx = ntx; brx = nrx;
    set_peer(bf, pa); set_peer(bf + 8, pb);
    bus_write(2'd0, a);
    while (ntx == btx) @(negedge clk);
    bus_write(2'd0, b);
    while (nr < br + 16) @(negedge clk);
    idle(3);
    chk("R5 first byte", sent_byte(bf), a);
    chk("R5 second byte", sent_byte(bf + 8), b);
    chk("R5 no gap across boundary", gap_errors(bf, 16, 2 * half_period(1, 1'b0)), 0);
    chk("R7 rx_irq only for first byte", nrx - brx, 1);
    bus_read(2'd1, r); chk("R7 OE set on overrun", r, 8'h0F);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, r); chk("R7 status write clears OE", r, 8'h07);
    bus_read(2'd0, r); chk("R7 buffer holds newer byte", r, pb);

    // R9 disabled port
    bus_write(2'd2, 8'h01);
    bf = nf; br = nr;
    set_peer(bf, 8'h96);
    bus_write(2'd0, 8'h69);
    idle(60);
    chk("R9 no clock while disabled", nf - bf, 0);
    chk("R9 sclk high while disabled", sclk_out, 1);
    bus_read(2'd1, r); chk("R9 byte held with TBE=0", r, 8'h04);
    bus_write(2'd2, 8'h41);
    while (nr < br + 8) @(negedge clk);
    idle(3);
    chk("R9 held byte sent after enable", sent_byte(bf), 8'h69);
    bus_read(2'd0, r); chk("R9 received after enable", r, 8'h96);

    // R10 external clock
    ext_mode = 1'b1;
    bus_write(2'd2, 8'h40);
    idle(2);
    chk("R10 clock output disabled", sclk_out_en, 0);
    brx = nrx;
    a = 8'($urandom); pa = 8'($urandom);
    bus_write(2'd0, a);
    idle(20);
    bus_read(2'd1, r); chk("R10 waits for external clock", r, 8'h04);
    ext_clock_byte(pa, g);
    idle(4);
    chk("R10 bits on external clock", g, a);
    bus_read(2'd1, r); chk("R10 status after external byte", r, 8'h07);
    bus_read(2'd0, r); chk("R10 received on external clock", r, pa);
    ext_clock_byte(8'h00, g);
    idle(4);
    bus_read(2'd1, r); chk("R10 idle edges ignored", r, 8'h05);
    chk("R10 no rx_irq from idle edges", nrx - brx, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule